// File: doc/BRIEF.md
# Configurable Port Pin Bank

This block controls a bank of port pins from a small set of configuration registers. Each pin has two mode bits. The input-mode bit selects an analog or a digital pin. The output-mode bit selects open-drain or push-pull driving. A control register holds three global bits: one that disables all weak pullups, one that enables the crossbar, and one that enables a single peripheral output.

From this state the block works out four values for every pin: the driver enable, the driven level, the weak-pullup enable and the digital receiver enable. It also decides which pin, if any, carries the peripheral output. All other pins drive the value held in the port latch.

The pad model sits outside this block and connects to its per-pin outputs. Software configures the bank through one write port and one read port. A skip mask keeps chosen pins out of peripheral routing, for example pins that serve analog inputs. Reading the port register returns the pad levels, which are sampled on each clock.

Top module: `gpio_pin_bank`

## Requirements
- R1: After reset the registers hold these values: port latch 0x00, input mode 0xFF (all pins digital), output mode 0x00 (all open-drain), skip mask 0x00, and control 0 (pullups allowed, crossbar off, peripheral off). Each of them reads back these values.
- R2: A pin whose input-mode bit is 0 (analog) has its driver enable, pullup enable and receiver enable all at 0.
- R3: A pin whose input-mode bit is 1 (digital) has its receiver enable at 1.
- R4: While control bit 1 (crossbar enable) is 0, every driver enable is 0.
- R5: The driven level of each pin equals its selected value. With the crossbar enabled, a digital push-pull pin (output-mode bit 1) drives both levels. A digital open-drain pin (output-mode bit 0) drives only when its value is 0.
- R6: A pullup is enabled only on a digital open-drain pin while control bit 0 (pullup disable) is 0. It is never enabled on a push-pull pin.
- R7: A pin whose driver is enabled at level 0 has its pullup disabled.
- R8: When control bit 2 (peripheral enable) and the crossbar enable are both 1, the peripheral output goes to the lowest-numbered pin that is digital and not skipped. That pin's selected value is then the peripheral data, and every other pin uses its latch bit. If no pin qualifies, or either enable bit is 0, no pin is selected.
- R9: A pin with its skip bit set, or in analog mode, is never selected for the peripheral.
- R10: A read of address 0 returns the pad levels sampled at the previous clock edge, masked to 0 on analog pins. Address 5 returns the port latch.
- R11: A write takes effect at the next clock edge. Addresses 0, 1, 2, 3 and 4 write the latch, input mode, output mode, skip mask and control registers. Reads of addresses 1 to 4 return those registers. Writes to addresses 5 to 7 change nothing, and reads of addresses 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | NUM_PINS | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | NUM_PINS | Register read data (combinational) |
| periph_dout | input | 1 | Peripheral output value to be routed |
| pad_in | input | NUM_PINS | Pad levels seen at the pins |
| pad_drv_en | output | NUM_PINS | Per-pin output driver enable |
| pad_drv_val | output | NUM_PINS | Per-pin driven level |
| pad_pullup_en | output | NUM_PINS | Per-pin weak pullup enable |
| pad_rx_en | output | NUM_PINS | Per-pin digital receiver enable |
| periph_sel | output | NUM_PINS | One-hot pin carrying the peripheral output, or zero |

## Verification
The assertions assume that every input is a known 0 or 1 at each rising clock edge and that rst_n is low from time zero until a few edges have passed. They also assume that NUM_PINS is at least three, so the control bits fit in the data word. The stimulus changes inputs only on falling edges and holds reset low for several cycles at the start. It uses the default width of eight pins. It sweeps many configurations of latch, modes, skip mask, control bits, pad levels and peripheral data, including a fully skipped bank and writes and reads at the unused addresses.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_PORT     = 3'd0,
    REG_INMODE   = 3'd1,
    REG_OUTMODE  = 3'd2,
    REG_SKIP     = 3'd3,
    REG_CTRL     = 3'd4,
    REG_LATCH_RB = 3'd5
  } reg_sel_e;

  localparam int CTRL_W = 3;

  typedef struct packed {
    logic periph_en;
    logic xbar_en;
    logic pud;
  } ctrl_t;

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_pin_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [NUM_PINS-1:0] wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [NUM_PINS-1:0] pad_q,
  output logic [NUM_PINS-1:0] latch,
  output logic [NUM_PINS-1:0] in_mode,
  output logic [NUM_PINS-1:0] out_mode,
  output logic [NUM_PINS-1:0] skip,
  output ctrl_t               ctrl,
  output logic [NUM_PINS-1:0] rd_data
);

  localparam int PAD_W = NUM_PINS - CTRL_W;

  logic [NUM_PINS-1:0] latch_q, latch_d;
  logic [NUM_PINS-1:0] inm_q, inm_d;
  logic [NUM_PINS-1:0] outm_q, outm_d;
  logic [NUM_PINS-1:0] skip_q, skip_d;
  ctrl_t               ctrl_q, ctrl_d;
  logic latch_ce, inm_ce, outm_ce, skip_ce, ctrl_ce;

  always_comb begin
    latch_ce = wr_en && (wr_addr == REG_PORT);
    inm_ce   = wr_en && (wr_addr == REG_INMODE);
    outm_ce  = wr_en && (wr_addr == REG_OUTMODE);
    skip_ce  = wr_en && (wr_addr == REG_SKIP);
    ctrl_ce  = wr_en && (wr_addr == REG_CTRL);
    latch_d  = wr_data;
    inm_d    = wr_data;
    outm_d   = wr_data;
    skip_d   = wr_data;
    ctrl_d   = ctrl_t'(wr_data[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      inm_q   <= '1;
      outm_q  <= '0;
      skip_q  <= '0;
      ctrl_q  <= '0;
    end else begin
      if (latch_ce) latch_q <= latch_d;
      if (inm_ce)   inm_q   <= inm_d;
      if (outm_ce)  outm_q  <= outm_d;
      if (skip_ce)  skip_q  <= skip_d;
      if (ctrl_ce)  ctrl_q  <= ctrl_d;
    end
  end

  always_comb begin
    case (rd_addr)
      REG_PORT:     rd_data = pad_q & inm_q;
      REG_INMODE:   rd_data = inm_q;
      REG_OUTMODE:  rd_data = outm_q;
      REG_SKIP:     rd_data = skip_q;
      REG_CTRL:     rd_data = {{PAD_W{1'b0}}, ctrl_q};
      REG_LATCH_RB: rd_data = latch_q;
      default:      rd_data = '0;
    endcase
  end

  assign latch    = latch_q;
  assign in_mode  = inm_q;
  assign out_mode = outm_q;
  assign skip     = skip_q;
  assign ctrl     = ctrl_q;

endmodule

// File: rtl/gpio_route_sel.sv
module gpio_route_sel #(
  parameter int NUM_PINS = 8
) (
  input  logic                enable,
  input  logic [NUM_PINS-1:0] cand,
  output logic [NUM_PINS-1:0] sel
);

  logic [NUM_PINS:0] taken;

  assign taken[0] = 1'b0;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chain
    assign sel[i]     = enable && cand[i] && !taken[i];
    assign taken[i+1] = taken[i] || cand[i];
  end

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell (
  input  logic digital,
  input  logic push_pull,
  input  logic pud,
  input  logic xbar_en,
  input  logic latch_bit,
  input  logic periph_hit,
  input  logic periph_dout,
  output logic drv_en,
  output logic drv_val,
  output logic pullup_en,
  output logic rx_en
);

  logic value;
  logic drive_ok;
  logic pulling_low;

  always_comb begin
    value       = periph_hit ? periph_dout : latch_bit;
    drive_ok    = xbar_en && digital;
    drv_en      = drive_ok && (push_pull || !value);
    drv_val     = value;
    pulling_low = drv_en && !value;
    pullup_en   = digital && !push_pull && !pud && !pulling_low;
    rx_en       = digital;
  end

endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
  import gpio_pin_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [2:0]          wr_addr,
  input  logic [NUM_PINS-1:0] wr_data,
  input  logic [2:0]          rd_addr,
  output logic [NUM_PINS-1:0] rd_data,
  input  logic                periph_dout,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_drv_en,
  output logic [NUM_PINS-1:0] pad_drv_val,
  output logic [NUM_PINS-1:0] pad_pullup_en,
  output logic [NUM_PINS-1:0] pad_rx_en,
  output logic [NUM_PINS-1:0] periph_sel
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_sync_n;
  logic [NUM_PINS-1:0]    pad_q, pad_d;
  logic [NUM_PINS-1:0]    latch, in_mode, out_mode, skip;
  ctrl_t                  ctrl;
  logic                   xbar_en;
  logic [NUM_PINS-1:0]    cand;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[SYNC_STAGES-1];

  assign pad_d = pad_in;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pad_q <= '0;
    else             pad_q <= pad_d;
  end

  gpio_cfg_regs #(.NUM_PINS(NUM_PINS)) regs_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .pad_q    (pad_q),
    .latch    (latch),
    .in_mode  (in_mode),
    .out_mode (out_mode),
    .skip     (skip),
    .ctrl     (ctrl),
    .rd_data  (rd_data)
  );

  assign xbar_en = ctrl.xbar_en;
  assign cand    = in_mode & ~skip;

  gpio_route_sel #(.NUM_PINS(NUM_PINS)) route_i (
    .enable (ctrl.periph_en && xbar_en),
    .cand   (cand),
    .sel    (periph_sel)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_pin_cell cell_i (
      .digital     (in_mode[p]),
      .push_pull   (out_mode[p]),
      .pud         (ctrl.pud),
      .xbar_en     (xbar_en),
      .latch_bit   (latch[p]),
      .periph_hit  (periph_sel[p]),
      .periph_dout (periph_dout),
      .drv_en      (pad_drv_en[p]),
      .drv_val     (pad_drv_val[p]),
      .pullup_en   (pad_pullup_en[p]),
      .rx_en       (pad_rx_en[p])
    );
  end

endmodule

// File: rtl/gpio_pin_bank_chk.sv
module gpio_pin_bank_chk #(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                xbar_en,
  input logic [NUM_PINS-1:0] in_mode,
  input logic [NUM_PINS-1:0] out_mode,
  input logic [NUM_PINS-1:0] skip,
  input logic                wr_en,
  input logic [2:0]          wr_addr,
  input logic [NUM_PINS-1:0] wr_data,
  input logic [2:0]          rd_addr,
  input logic [NUM_PINS-1:0] rd_data,
  input logic [NUM_PINS-1:0] pad_drv_en,
  input logic [NUM_PINS-1:0] pad_drv_val,
  input logic [NUM_PINS-1:0] pad_pullup_en,
  input logic [NUM_PINS-1:0] pad_rx_en,
  input logic [NUM_PINS-1:0] periph_sel
);

  assert_analog_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_drv_en | pad_pullup_en) & ~pad_rx_en) == '0);

  assert_xbar_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !xbar_en |-> (pad_drv_en == '0));

  assert_pp_no_pull_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pullup_en & out_mode) == '0);

  assert_low_no_pull_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pullup_en & pad_drv_en & ~pad_drv_val) == '0);

  assert_route_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(periph_sel));

  assert_skip_excluded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_sel & (skip | ~in_mode)) == '0);

  assert_port_read_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 3'd0) |-> ((rd_data & ~pad_rx_en) == '0));

  assert_skip_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd3) |=> (skip == $past(wr_data)));

endmodule

bind gpio_pin_bank gpio_pin_bank_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .xbar_en       (xbar_en),
  .in_mode       (in_mode),
  .out_mode      (out_mode),
  .skip          (skip),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .wr_data       (wr_data),
  .rd_addr       (rd_addr),
  .rd_data       (rd_data),
  .pad_drv_en    (pad_drv_en),
  .pad_drv_val   (pad_drv_val),
  .pad_pullup_en (pad_pullup_en),
  .pad_rx_en     (pad_rx_en),
  .periph_sel    (periph_sel)
);

// File: tb/gpio_pin_bank_tb_top.sv
module gpio_pin_bank_tb_top;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [N-1:0] wr_data = '0;
  logic [2:0]   rd_addr = '0;
  logic [N-1:0] rd_data;
  logic         periph_dout = 1'b0;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_drv_en, pad_drv_val, pad_pullup_en, pad_rx_en, periph_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_pin_bank #(.NUM_PINS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .periph_dout(periph_dout), .pad_in(pad_in), .pad_drv_en(pad_drv_en),
    .pad_drv_val(pad_drv_val), .pad_pullup_en(pad_pullup_en),
    .pad_rx_en(pad_rx_en), .periph_sel(periph_sel)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [2:0] a, input logic [N-1:0] exp);
    rd_addr = a;
    #1;
    check(tag, rd_data, exp);
  endtask

  // model state
  logic [N-1:0] m_latch, m_inm, m_outm, m_skip;
  logic [2:0]   m_ctrl;

  task automatic check_pins(input logic pd);
    logic [N-1:0] cand, sel, e_drv, e_val, e_pu;
    logic         en;
    logic         found;
    cand  = m_inm & ~m_skip;
    en    = m_ctrl[2] & m_ctrl[1];
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (en && cand[i] && !found) begin sel[i] = 1'b1; found = 1'b1; end
    end
    for (int i = 0; i < N; i++) begin
      e_val[i] = sel[i] ? pd : m_latch[i];
      e_drv[i] = m_ctrl[1] & m_inm[i] & (m_outm[i] | ~e_val[i]);
      e_pu[i]  = m_inm[i] & ~m_outm[i] & ~m_ctrl[0] & ~(e_drv[i] & ~e_val[i]);
    end
    check("R8 route", periph_sel, sel);
    check("R5 drv_val", pad_drv_val, e_val);
    check("R4/R5 drv_en", pad_drv_en, e_drv);
    check("R6/R7 pullup", pad_pullup_en, e_pu);
    check("R2/R3 rx_en", pad_rx_en, m_inm);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    logic [N-1:0] pads;
    seed = 32'h1234_5678;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    rd_check("R1 latch", 3'd5, 8'h00);
    rd_check("R1 inmode", 3'd1, 8'hFF);
    rd_check("R1 outmode", 3'd2, 8'h00);
    rd_check("R1 skip", 3'd3, 8'h00);
    rd_check("R1 ctrl", 3'd4, 8'h00);
    m_latch = 8'h00; m_inm = 8'hFF; m_outm = 8'h00; m_skip = 8'h00; m_ctrl = 3'b000;
    check_pins(1'b0);

    for (int k = 0; k < 1024; k++) begin
      seed = seed * 32'd1103515245 + 32'd12345; m_latch = seed[23:16];
      seed = seed * 32'd1103515245 + 32'd12345; m_inm   = seed[23:16] | seed[15:8];
      seed = seed * 32'd1103515245 + 32'd12345; m_outm  = seed[23:16];
      seed = seed * 32'd1103515245 + 32'd12345; m_skip  = seed[23:16] & seed[15:8];
      seed = seed * 32'd1103515245 + 32'd12345; pads    = seed[23:16];
      m_ctrl = k[2:0];
      if (k % 64 == 5)  m_skip = 8'hFF;
      if (k % 64 == 9)  m_inm  = 8'h00;
      if (k % 32 == 11) begin m_inm = 8'hFF; m_skip = 8'h00; end
      wr(3'd0, m_latch);
      wr(3'd1, m_inm);
      wr(3'd2, m_outm);
      wr(3'd3, m_skip);
      wr(3'd4, {5'b0, m_ctrl});
      pad_in = pads;
      periph_dout = seed[3];
      @(negedge clk);
      check_pins(seed[3]);
      periph_dout = ~seed[3];
      #1;
      check_pins(~seed[3]);
      rd_check("R10 port read", 3'd0, pads & m_inm);
      rd_check("R10 latch read", 3'd5, m_latch);
      rd_check("R11 inmode read", 3'd1, m_inm);
      rd_check("R11 outmode read", 3'd2, m_outm);
      rd_check("R11 skip read", 3'd3, m_skip);
      rd_check("R11 ctrl read", 3'd4, {5'b0, m_ctrl});
    end

    // R11 writes to unused addresses are ignored; unused reads are zero
    wr(3'd5, ~m_latch);
    wr(3'd6, ~m_inm);
    wr(3'd7, ~m_skip);
    rd_check("R11 addr5 write ignored", 3'd5, m_latch);
    rd_check("R11 inmode unchanged", 3'd1, m_inm);
    rd_check("R11 skip unchanged", 3'd3, m_skip);
    rd_check("R11 read addr6", 3'd6, 8'h00);
    rd_check("R11 read addr7", 3'd7, 8'h00);
    check_pins(periph_dout);

    // R10 one-cycle sampling of pads
    wr(3'd1, 8'hFF);
    m_inm = 8'hFF;
    pad_in = 8'hA5;
    @(negedge clk);
    pad_in = 8'h3C;
    rd_check("R10 sample previous edge", 3'd0, 8'hA5);
    @(negedge clk);
    rd_check("R10 sample next edge", 3'd0, 8'h3C);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule